// File: doc/BRIEF.md
# Pin-Change and External Interrupt Controller

This block collects interrupt requests for a small CPU from two kinds of sources. The first is one dedicated external interrupt pin whose sensing can be set to a low level or to a rising edge, a falling edge or either edge. The second is four groups of eight general-purpose pins. Any level change on an unmasked pin of a group sets one flag that the whole group shares. Every pin is synchronized before it is sensed. Sensing looks only at the pin value, so a pin that the chip drives as an output still raises requests.

Software configures the block through a byte-wide register bus with eight addresses. It holds one mask byte per group, a group-enable register, a sense-mode register and a flag register. Each source drives its own request output. A request is gated by its enable bit and by a global interrupt enable input. When the CPU takes a vector it pulses the matching acknowledge input, which clears the flag. Software can also clear a flag by writing a one to it.

A build parameter can remove the upper two pin groups. Their flags, enables and masks then read as zero and ignore writes.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset every flag, group enable, external enable, mask byte and the sense mode are zero, and all request outputs are low.
- R2: A change in either direction on a pin whose mask bit is one sets the flag of that pin's group. The flag is visible after the third rising clock edge that follows the pin change and is not yet set after the second. A change on a pin whose mask bit is zero sets nothing.
- R3: Group request g equals flag g AND group enable g AND the global enable. The external request in an edge mode equals the external flag AND the external enable AND the global enable. These are combinational from the registers.
- R4: A one on ack_grp[g] for one cycle clears group flag g, and a one on ack_ext clears the external flag.
- R5: Writing the flag register (address 0) clears every flag whose written bit is one. Written zero bits leave their flags unchanged.
- R6: When a set event and a clear (by write or by acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R7: Flag register layout is: bit 7 = group 3, bit 6 = group 2, bit 5 = group 1, bit 4 = group 0, bit 0 = external pin. Bits 3..1 always read zero. The enable register (address 1) uses the same positions for the group enables and the external enable. Address 2 holds the sense mode in bits 1..0. Addresses 4 to 7 hold the mask bytes of groups 0 to 3, and mask bit b covers pin 8g+b.
- R8: Sense codes 01 (either edge), 10 (falling) and 11 (rising) set the external flag on the matching transitions only, with the same three-edge latency as R2.
- R9: Sense code 00 (low level) latches no flag. The external request is then external enable AND global enable AND the synchronized pin being low, and it follows the pin after the second rising edge.
- R10: With the upper groups removed, flag bits 7 and 6, enable bits 7 and 6 and the mask bytes at addresses 6 and 7 read zero whatever is written and whatever the pins do. Groups 0 and 1 behave as before.
- R11: Group g covers pins 8g+7 down to 8g. A change on a pin sets only its own group's flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gie | input | 1 | Global interrupt enable from the CPU |
| ext_pin | input | 1 | Dedicated external interrupt pin |
| pc_pin | input | 32 | Pin-change pins, group g on bits 8g+7..8g |
| ack_ext | input | 1 | Vector-taken acknowledge for the external interrupt |
| ack_grp | input | 4 | Vector-taken acknowledge per pin group |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from bus_addr |
| req_ext | output | 1 | External interrupt request |
| req_grp | output | 4 | Pin-change group requests |

## Verification
A pin driven on a falling clock edge reaches the second synchronizer stage after two rising edges. Its flag is then due after the third rising edge, so the bench reads the flag register just before the third edge, expecting it clear, and again just after it, expecting it set. A level-mode request is due after the second rising edge and is bracketed the same way. Requests, read data and register writes are combinational or take one edge, and the bench samples them one time unit after it drives a falling-edge input. The same-cycle collisions are created by launching the write or acknowledge in the half cycle just before the edge that also sets the flag.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  localparam int ADDR_FLAG  = 0;
  localparam int ADDR_EN    = 1;
  localparam int ADDR_SENSE = 2;
  localparam int ADDR_MASK0 = 4;

  // Edge event for the dedicated pin; level mode never produces an event.
  function automatic logic edge_hit(sense_e mode, logic cur, logic prev);
    case (mode)
      SNS_ANY:  return cur ^ prev;
      SNS_FALL: return prev & ~cur;
      SNS_RISE: return cur & ~prev;
      default:  return 1'b0;
    endcase
  endfunction

  // Any change on an enabled pin of a group.
  function automatic logic group_hit(logic [7:0] cur, logic [7:0] prev, logic [7:0] mask);
    return |((cur ^ prev) & mask);
  endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur    <= '0;
      prev   <= '0;
    end else begin
      meta_q <= din;
      cur    <= meta_q;
      prev   <= cur;
    end
  end
endmodule

// File: rtl/xirq_flag.sv
module xirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n) set |=> q);
  // R4
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n) (clr && !set) |=> !q);
  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (!clr && !set) |=> $stable(q));
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int GRP_W        = 8,
  parameter int GRP_MAX      = 4,
  parameter bit UPPER_GROUPS = 1'b1,
  parameter int AW           = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     gie,
  input  logic                     ext_pin,
  input  logic [GRP_MAX*GRP_W-1:0] pc_pin,
  input  logic                     ack_ext,
  input  logic [GRP_MAX-1:0]       ack_grp,
  input  logic                     bus_wr,
  input  logic [AW-1:0]            bus_addr,
  input  logic [7:0]               bus_wdata,
  output logic [7:0]               bus_rdata,
  output logic                     req_ext,
  output logic [GRP_MAX-1:0]       req_grp
);
  localparam int NGRP     = UPPER_GROUPS ? GRP_MAX : GRP_MAX / 2;
  localparam int NPIN     = GRP_MAX * GRP_W;
  localparam int FLAG_LSB = 8 - GRP_MAX;
  localparam logic [GRP_MAX-1:0] GRP_PRESENT = GRP_MAX'((1 << NGRP) - 1);

  // configuration registers
  logic [GRP_MAX-1:0] en_grp_q;
  logic               en_ext_q;
  sense_e             sense_q;
  logic [GRP_W-1:0]   mask_q [GRP_MAX];

  // named internal events
  logic [NPIN:0]      sync_cur, sync_prev;
  logic               ext_cur, ext_prev, ext_evt, ext_clr, ext_flag;
  logic [GRP_MAX-1:0] grp_evt, grp_clr, grp_flag;
  logic               wr_flag;

  assign wr_flag = bus_wr && (bus_addr == AW'(ADDR_FLAG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_grp_q <= '0;
      en_ext_q <= 1'b0;
      sense_q  <= SNS_LOW;
      for (int g = 0; g < GRP_MAX; g++) mask_q[g] <= '0;
    end else if (bus_wr) begin
      if (bus_addr == AW'(ADDR_EN)) begin
        en_grp_q <= bus_wdata[7:FLAG_LSB] & GRP_PRESENT;
        en_ext_q <= bus_wdata[0];
      end
      if (bus_addr == AW'(ADDR_SENSE)) sense_q <= sense_e'(bus_wdata[1:0]);
      for (int g = 0; g < NGRP; g++)
        if (bus_addr == AW'(ADDR_MASK0 + g)) mask_q[g] <= bus_wdata[GRP_W-1:0];
    end
  end

  xirq_sync #(.W(NPIN + 1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ext_pin, pc_pin}),
    .cur  (sync_cur),
    .prev (sync_prev)
  );

  assign ext_cur  = sync_cur[NPIN];
  assign ext_prev = sync_prev[NPIN];
  assign ext_evt  = edge_hit(sense_q, ext_cur, ext_prev);
  assign ext_clr  = (wr_flag && bus_wdata[0]) || ack_ext;

  xirq_flag u_ext_flag (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (ext_evt),
    .clr  (ext_clr),
    .q    (ext_flag)
  );

  for (genvar g = 0; g < GRP_MAX; g++) begin : g_grp
    if (g < NGRP) begin : g_on
      assign grp_evt[g] = group_hit(sync_cur[g*GRP_W +: GRP_W], sync_prev[g*GRP_W +: GRP_W], mask_q[g]);
      assign grp_clr[g] = (wr_flag && bus_wdata[FLAG_LSB + g]) || ack_grp[g];
      xirq_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (grp_evt[g]),
        .clr  (grp_clr[g]),
        .q    (grp_flag[g])
      );
      // R2
      flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grp_flag[g]) |-> $past(grp_evt[g]));
    end else begin : g_off
      assign grp_evt[g]  = 1'b0;
      assign grp_clr[g]  = 1'b0;
      assign grp_flag[g] = 1'b0;
    end
  end

  assign req_grp = grp_flag & en_grp_q & {GRP_MAX{gie}};
  assign req_ext = gie && en_ext_q && ((sense_q == SNS_LOW) ? !ext_cur : ext_flag);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(ADDR_FLAG))  bus_rdata = {grp_flag, {(FLAG_LSB-1){1'b0}}, ext_flag};
    if (bus_addr == AW'(ADDR_EN))    bus_rdata = {en_grp_q, {(FLAG_LSB-1){1'b0}}, en_ext_q};
    if (bus_addr == AW'(ADDR_SENSE)) bus_rdata = {6'b0, sense_q};
    for (int g = 0; g < GRP_MAX; g++)
      if (bus_addr == AW'(ADDR_MASK0 + g)) bus_rdata = 8'(mask_q[g]);
  end

  // R3
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (req_grp == '0 && !req_ext));
  // R7
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(ADDR_FLAG)) |-> (bus_rdata[3:1] == 3'b000));
  // R9
  lvl_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_q == SNS_LOW && !ext_flag) |=> !ext_flag);
  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ext && !ext_evt) |=> !ext_flag);
endmodule

// File: tb/tb_xirq_ctrl.sv
module tb_xirq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gie = 1'b0;
  logic        ext_pin = 1'b0;
  logic [31:0] pc_pin = '0;
  logic        ack_ext = 1'b0;
  logic [3:0]  ack_grp = '0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  rdata, rdata_l;
  logic        req_ext, req_ext_l;
  logic [3:0]  req_grp, req_grp_l;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  xirq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .gie(gie), .ext_pin(ext_pin), .pc_pin(pc_pin),
    .ack_ext(ack_ext), .ack_grp(ack_grp), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .req_ext(req_ext), .req_grp(req_grp)
  );

  xirq_ctrl #(.UPPER_GROUPS(1'b0)) dut_lite (
    .clk(clk), .rst_n(rst_n), .gie(gie), .ext_pin(ext_pin), .pc_pin(pc_pin),
    .ack_ext(ack_ext), .ack_grp(ack_grp), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_l), .req_ext(req_ext_l), .req_grp(req_grp_l)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; one write cycle, returns at the next falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic [7:0] dl);
    bus_addr = a;
    #1;
    d = rdata;
    dl = rdata_l;
  endtask

  // expected flag register bit of the group owning a pin
  function automatic logic [7:0] grp_bit(input int p);
    return 8'(1 << (4 + p / 8));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, dl, exp_f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d, dl);
      chk("R1 register after reset", {24'b0, d}, 32'h0);
    end
    chk("R1 requests after reset", {27'b0, req_ext, req_grp}, 32'h0);

    // R7 / R10 register layout
    @(negedge clk);
    wr(3'd1, 8'hF1);
    rd(3'd1, d, dl);
    chk("R7 enable register", {24'b0, d}, 32'hF1);
    chk("R10 enable upper bits absent", {24'b0, dl}, 32'h31);
    wr(3'd6, 8'hFF);
    rd(3'd6, d, dl);
    chk("R10 mask byte 6 absent", {24'b0, dl}, 32'h0);
    chk("R7 mask byte 6", {24'b0, d}, 32'hFF);
    gie = 1'b1;

    // R2 R11 R10 R3 R4 R5: sweep every pin under two mask patterns
    for (int pat = 0; pat < 2; pat++) begin
      logic [7:0] m;
      m = (pat == 0) ? 8'hFF : 8'h5A;
      for (int g = 0; g < 4; g++) wr(3'(4 + g), m);
      for (int p = 0; p < 32; p++) begin
        exp_f = m[p % 8] ? grp_bit(p) : 8'h00;
        pc_pin[p] = ~pc_pin[p];
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd(3'd0, d, dl);
        chk("R2 flag not before third edge", {24'b0, d}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        rd(3'd0, d, dl);
        chk("R2 R11 group flag", {24'b0, d}, {24'b0, exp_f});
        chk("R10 lite flag", {24'b0, dl}, {24'b0, (p < 16) ? exp_f : 8'h00});
        chk("R3 group request", {28'b0, req_grp}, {28'b0, exp_f[7:4]});
        if (exp_f != 0) begin
          wr(3'd0, 8'h0F);
          rd(3'd0, d, dl);
          chk("R5 write zero keeps flag", {24'b0, d}, {24'b0, exp_f});
          if (p % 2 == 1) begin
            ack_grp = exp_f[7:4];
            @(posedge clk);
            @(negedge clk);
            ack_grp = '0;
          end else begin
            wr(3'd0, exp_f);
          end
          rd(3'd0, d, dl);
          chk(p % 2 == 1 ? "R4 ack clears flag" : "R5 write one clears flag", {24'b0, d}, 32'h0);
        end
      end
    end

    // R3 global and group gating
    for (int g = 0; g < 4; g++) wr(3'(4 + g), 8'hFF);
    pc_pin[9] = ~pc_pin[9];
    repeat (3) @(posedge clk);
    @(negedge clk);
    gie = 1'b0;
    #1;
    chk("R3 gie low masks request", {28'b0, req_grp}, 32'h0);
    gie = 1'b1;
    #1;
    chk("R3 gie high passes request", {28'b0, req_grp}, 32'h2);
    wr(3'd1, 8'hD1);
    chk("R3 group enable low masks request", {28'b0, req_grp}, 32'h0);
    wr(3'd1, 8'hF1);
    wr(3'd0, 8'hFF);

    // R6 set beats a same-cycle write-one clear
    pc_pin[3] = ~pc_pin[3];
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr(3'd0, 8'h10);
    rd(3'd0, d, dl);
    chk("R6 set wins over write clear", {24'b0, d}, 32'h10);
    wr(3'd0, 8'hFF);
    // R6 set beats a same-cycle acknowledge
    pc_pin[20] = ~pc_pin[20];
    repeat (2) @(posedge clk);
    @(negedge clk);
    ack_grp = 4'b0100;
    @(posedge clk);
    @(negedge clk);
    ack_grp = '0;
    rd(3'd0, d, dl);
    chk("R6 set wins over ack", {24'b0, d}, 32'h40);
    wr(3'd0, 8'hFF);

    // R7 reserved bits
    wr(3'd0, 8'h0E);
    rd(3'd0, d, dl);
    chk("R7 reserved bits read zero", {24'b0, d & 8'h0E}, 32'h0);

    // R8 edge sense modes, rise then fall
    for (int md = 1; md < 4; md++) begin
      wr(3'd2, 8'(md));
      for (int dir = 0; dir < 2; dir++) begin
        logic e;
        e = (md == 1) || (dir == 0 && md == 3) || (dir == 1 && md == 2);
        ext_pin = (dir == 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(3'd0, d, dl);
        chk("R8 external flag for sense mode", {24'b0, d}, {31'b0, e});
        chk("R3 external request", {31'b0, req_ext}, {31'b0, e});
        if (e) begin
          ack_ext = 1'b1;
          @(posedge clk);
          @(negedge clk);
          ack_ext = 1'b0;
          rd(3'd0, d, dl);
          chk("R4 ack clears external flag", {24'b0, d}, 32'h0);
        end
      end
    end

    // R9 level mode
    wr(3'd2, 8'h00);
    ext_pin = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 level high no request", {31'b0, req_ext}, 32'h0);
    ext_pin = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R9 level not before second edge", {31'b0, req_ext}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 level low requests", {31'b0, req_ext}, 32'h1);
    rd(3'd0, d, dl);
    chk("R9 level latches no flag", {24'b0, d}, 32'h0);
    ext_pin = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 level request follows pin", {31'b0, req_ext}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule